// File: doc/BRIEF.md
# Cascadable Timebase Interrupt Counter

This block produces periodic interrupts from an 8-bit up-counter. The counter runs free. In its own mode it advances once per tick of an internal prescaler that divides the system clock by a power of two from 2 to 256. When it passes from FFh to 00h it sets a sticky overflow flag, and a level interrupt request follows that flag while interrupts are enabled. To get a given delay, software preloads the counter with 256 minus the number of ticks wanted. For example, E0h at divide-by-256 overflows after 32 ticks, which is 8192 clocks.

A cascade bit takes the counter off the prescaler. The counter then advances on a carry pulse from an external 8-bit timer and forms the upper byte of a 16-bit count. Software reaches the block through a two-register interface. Register select 0 is the counter value, which can be written at any time, including while it counts. Register select 1 is the control/status byte. Reading the control byte clears the overflow flag.

Top module: `tick_chain_timer`

## Requirements
- R1: After reset the counter reads 00h, the control byte reads 00h and irqOut is low.
- R2: With the enable bit (control bit 4) set and the cascade bit (bit 5) clear, the counter advances by one every 2^(P+1) clocks. P is the prescaler select in control bits 2:0. After enable is written, the first step lands on the 2^(P+1)-th rising edge.
- R3: A step from FFh to 00h sets the overflow flag, which reads as control bit 7. irqOut is high while both that flag and interrupt-enable (control bit 3) are set.
- R4: With interrupt-enable clear, an overflow still sets the flag but irqOut stays low.
- R5: A read of the control byte (regRdEn with regSel=1) clears the overflow flag on the following edge. If an overflow happens on that same edge, the flag stays set.
- R6: While enable is clear the counter holds its value. Setting enable again resumes counting from the held value, with no reload, and the prescaler starts a full period afresh.
- R7: A counter write (regWrEn with regSel=0) takes effect on the next edge. It wins over a step due on the same edge.
- R8: With cascade and enable set, the counter advances once per clock in which carryIn is high, and the prescaler has no effect. Cascade with enable clear does not count.
- R9: With cascade clear, carryIn has no effect on the counter.
- R10: A write to the control byte cannot set bit 7, and bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears the flag when the control byte is read) |
| regSel | input | 1 | 0 selects the counter, 1 selects the control byte |
| regWrData | input | 8 | Write data |
| carryIn | input | 1 | Carry pulse from the external low-byte timer |
| regRdData | output | 8 | Read data for the selected register (combinational) |
| irqOut | output | 1 | Level interrupt request |

## Verification
Register writes, counter steps, flag set and flag clear all land on the rising edge right after the cycle that causes them. Read data and irqOut follow that state combinationally, without any extra register stage. A prescaled step lands exactly 2^(P+1) edges after the enabling write. The bench drives on the falling edge and samples half a cycle after each edge. For each timing case it checks the edge before the expected change as well as the edge of the change, so that a result one cycle early or one cycle late is reported. The same-edge collisions, which are a write against a step and a clear against an overflow, are lined up by counting edges from a known enable point.

// File: rtl/tick_chain_pkg.sv
package tick_chain_pkg;
  localparam int DATA_W  = 8;
  localparam int PR_W    = 3;
  localparam int ITE_BIT = 3;
  localparam int EN_BIT  = 4;
  localparam int CAS_BIT = 5;
  localparam int OVF_BIT = 7;

  typedef struct packed {
    logic cntLoad;   // software write to the counter
    logic cntInc;    // advance the counter by one
    logic ovfClear;  // control byte was read
  } strobe_t;
endpackage

// File: rtl/tick_chain_ctrl.sv
module tick_chain_ctrl
  import tick_chain_pkg::*;
#(
  parameter int PSEL_W = PR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regSel,
  input  logic [CAS_BIT:0]  ctrlWrData,
  input  logic              carryIn,
  output strobe_t           strobe,
  output logic [PSEL_W-1:0] prSel,
  output logic              ite,
  output logic              enable,
  output logic              cascade
);
  localparam int PRESC_W = 1 << PSEL_W;

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] divTick;
  logic               prescTick;
  logic               ctrlWr;

  // One terminal-count decode per division setting
  for (genvar i = 0; i < PRESC_W; i++) begin : g_div
    assign divTick[i] = &presc[i:0];
  end

  assign prescTick = divTick[prSel];
  assign ctrlWr    = regWrEn && regSel;

  always_comb begin
    strobe.cntLoad  = regWrEn && !regSel;
    strobe.cntInc   = enable && (cascade ? carryIn : prescTick);
    strobe.ovfClear = regRdEn && regSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prSel   <= '0;
      ite     <= 1'b0;
      enable  <= 1'b0;
      cascade <= 1'b0;
    end else if (ctrlWr) begin
      prSel   <= ctrlWrData[PSEL_W-1:0];
      ite     <= ctrlWrData[ITE_BIT];
      enable  <= ctrlWrData[EN_BIT];
      cascade <= ctrlWrData[CAS_BIT];
    end
  end

  // Held at zero while stopped or cascaded, so each enable starts a full period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    presc <= '0;
    else if (enable && !cascade)  presc <= presc + 1'b1;
    else                          presc <= '0;
  end
endmodule

// File: rtl/tick_chain_dp.sv
module tick_chain_dp
  import tick_chain_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic wrap;

  assign wrap = strobe.cntInc && !strobe.cntLoad && (&count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.cntLoad) count <= loadValue;
    else if (strobe.cntInc)  count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovf <= 1'b0;
    else if (wrap)            ovf <= 1'b1;
    else if (strobe.ovfClear) ovf <= 1'b0;
  end
endmodule

// File: rtl/tick_chain_timer.sv
module tick_chain_timer
  import tick_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              carryIn,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  strobe_t           strobe;
  logic [PR_W-1:0]   prSel;
  logic              ite;
  logic              enable;
  logic              cascade;
  logic [DATA_W-1:0] count;
  logic              ovf;
  logic [DATA_W-1:0] ctrlByte;

  tick_chain_ctrl #(.PSEL_W(PR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regSel     (regSel),
    .ctrlWrData (regWrData[CAS_BIT:0]),
    .carryIn    (carryIn),
    .strobe     (strobe),
    .prSel      (prSel),
    .ite        (ite),
    .enable     (enable),
    .cascade    (cascade)
  );

  tick_chain_dp #(.CNT_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadValue (regWrData),
    .count     (count),
    .ovf       (ovf)
  );

  always_comb begin
    ctrlByte             = '0;
    ctrlByte[PR_W-1:0]   = prSel;
    ctrlByte[ITE_BIT]    = ite;
    ctrlByte[EN_BIT]     = enable;
    ctrlByte[CAS_BIT]    = cascade;
    ctrlByte[OVF_BIT]    = ovf;
  end

  assign regRdData = regSel ? ctrlByte : count;
  assign irqOut    = ovf && ite;
endmodule

// File: rtl/tick_chain_checker.sv
module tick_chain_checker
  import tick_chain_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           strobe,
  input logic [DATA_W-1:0] count,
  input logic              ovf,
  input logic              ite,
  input logic              enable,
  input logic              irqOut,
  input logic              regWrEn,
  input logic              regSel,
  input logic [DATA_W-1:0] regWrData
);
  // R7: a counter write lands on the next edge whatever else happens
  a_r7_write_priority: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel) |=> (count == $past(regWrData)));

  // R2: a step moves the count by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntInc && !strobe.cntLoad) |=> (count == DATA_W'($past(count) + 1)));

  // R6: stopped counter keeps its value
  a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !(regWrEn && !regSel)) |=> $stable(count));

  // R3: wrap sets the flag
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntInc && !strobe.cntLoad && (&count)) |=> ovf);

  // R5: read clears the flag unless a wrap coincides
  a_r5_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ovfClear && !(strobe.cntInc && !strobe.cntLoad && (&count))) |=> !ovf);

  // R5: the flag is sticky without a read
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobe.ovfClear) |=> ovf);

  // R4: no request while interrupts are masked
  a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ite |-> !irqOut);
endmodule

bind tick_chain_timer tick_chain_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strobe    (strobe),
  .count     (count),
  .ovf       (ovf),
  .ite       (ite),
  .enable    (enable),
  .irqOut    (irqOut),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData)
);

// File: tb/tick_chain_timer_bench.sv
module tick_chain_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic       carryIn = 1'b0;
  logic [7:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tick_chain_timer u_tick_chain_timer (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .carryIn   (carryIn),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] data);
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peekCount(output logic [7:0] v);
    regSel = 1'b0; #1; v = regRdData;
  endtask

  task automatic readCtrl(output logic [7:0] v);
    regSel = 1'b1; regRdEn = 1'b1; #1; v = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic restart(input logic [7:0] cnt);
    logic [7:0] junk;
    wrReg(1'b1, 8'h00);
    wrReg(1'b0, cnt);
    readCtrl(junk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    peekCount(v);  check("R1 count", v, 8'h00);
    readCtrl(v);   check("R1 ctrl", v, 8'h00);
    check("R1 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testPrescale(input int pr, input int ticks);
    logic [7:0] v;
    int div = 2 << pr;
    restart(8'h00);
    wrReg(1'b1, 8'h10 | 8'(pr));
    waitCyc(ticks * div - 1);
    peekCount(v); check($sformatf("R2 pr%0d before step", pr), v, 8'(ticks - 1));
    waitCyc(1);
    peekCount(v); check($sformatf("R2 pr%0d at step", pr), v, 8'(ticks));
  endtask

  task automatic testOverflowIrq();
    logic [7:0] v;
    restart(8'hFE);
    wrReg(1'b1, 8'h18);
    waitCyc(3);
    peekCount(v); check("R3 count before wrap", v, 8'hFF);
    check("R3 irq before wrap", {7'b0, irqOut}, 8'h00);
    waitCyc(1);
    peekCount(v); check("R3 count after wrap", v, 8'h00);
    check("R3 irq after wrap", {7'b0, irqOut}, 8'h01);
    readCtrl(v);  check("R3 ctrl shows flag", v, 8'h98);
    check("R5 irq after read", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testMaskedFlag();
    logic [7:0] v;
    restart(8'hFE);
    wrReg(1'b1, 8'h10);
    waitCyc(4);
    check("R4 irq masked", {7'b0, irqOut}, 8'h00);
    readCtrl(v); check("R4 flag set", v, 8'h90);
    readCtrl(v); check("R5 flag cleared", v, 8'h10);
  endtask

  task automatic testSetWins();
    logic [7:0] v;
    restart(8'hFE);
    wrReg(1'b1, 8'h18);
    waitCyc(3);
    readCtrl(v); check("R5 flag before coincident edge", v, 8'h18);
    check("R5 set wins over clear", {7'b0, irqOut}, 8'h01);
    readCtrl(v); check("R5 flag kept", v, 8'h98);
    check("R5 irq cleared later", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testExample();
    logic [7:0] v;
    restart(8'hE0);
    wrReg(1'b1, 8'h1F);
    waitCyc(8191);
    check("R3 div256 irq early", {7'b0, irqOut}, 8'h00);
    waitCyc(1);
    check("R3 div256 irq due", {7'b0, irqOut}, 8'h01);
    peekCount(v); check("R3 div256 count", v, 8'h00);
  endtask

  task automatic testDisableResume();
    logic [7:0] v;
    restart(8'h10);
    wrReg(1'b1, 8'h10);
    waitCyc(3);
    peekCount(v); check("R6 running", v, 8'h11);
    wrReg(1'b1, 8'h00);
    peekCount(v); check("R6 last step", v, 8'h12);
    waitCyc(10);
    peekCount(v); check("R6 held", v, 8'h12);
    wrReg(1'b1, 8'h10);
    waitCyc(1);
    peekCount(v); check("R6 no reload, full period", v, 8'h12);
    waitCyc(1);
    peekCount(v); check("R6 resumed", v, 8'h13);
  endtask

  task automatic testWritePriority();
    logic [7:0] v;
    restart(8'h00);
    wrReg(1'b1, 8'h10);
    waitCyc(1);
    wrReg(1'b0, 8'h40);
    peekCount(v); check("R7 write wins", v, 8'h40);
    waitCyc(1);
    peekCount(v); check("R7 hold to next step", v, 8'h40);
    waitCyc(1);
    peekCount(v); check("R7 step after write", v, 8'h41);
  endtask

  task automatic pulseCarry(input int n);
    for (int i = 0; i < n; i++) begin
      carryIn = 1'b1; @(negedge clk);
      carryIn = 1'b0; @(negedge clk);
    end
  endtask

  task automatic testCascade();
    logic [7:0] v;
    restart(8'h05);
    wrReg(1'b1, 8'h30);
    pulseCarry(3);
    waitCyc(20);
    peekCount(v); check("R8 carry steps only", v, 8'h08);
    wrReg(1'b1, 8'h38);
    wrReg(1'b0, 8'hFF);
    pulseCarry(1);
    peekCount(v); check("R8 cascade wrap", v, 8'h00);
    check("R8 cascade irq", {7'b0, irqOut}, 8'h01);
    readCtrl(v); check("R8 ctrl", v, 8'hB8);
    wrReg(1'b1, 8'h20);
    pulseCarry(2);
    peekCount(v); check("R8 stopped in cascade", v, 8'h00);
  endtask

  task automatic testCarryIgnored();
    logic [7:0] v;
    restart(8'h20);
    wrReg(1'b1, 8'h17);
    carryIn = 1'b1;
    waitCyc(10);
    carryIn = 1'b0;
    peekCount(v); check("R9 carry ignored", v, 8'h20);
  endtask

  task automatic testReadOnlyBits();
    logic [7:0] v;
    restart(8'h00);
    wrReg(1'b1, 8'hFF);
    readCtrl(v); check("R10 ctrl readback", v, 8'h3F);
    check("R10 no irq", {7'b0, irqOut}, 8'h00);
    wrReg(1'b1, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrescale(0, 5);
    testPrescale(2, 3);
    testPrescale(7, 2);
    testOverflowIrq();
    testMaskedFlag();
    testSetWins();
    testExample();
    testDisableResume();
    testWritePriority();
    testCascade();
    testCarryIgnored();
    testReadOnlyBits();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule